// File: doc/BRIEF.md
# FIFO Status and Edge Interrupt Unit

This unit gathers the live condition of a serial controller's two byte FIFOs and its transfer sequencer into one registered status word. From the FIFO fill levels it derives empty, full and threshold-based ready flags. It keeps sticky records of overflow and underflow events, and it passes through the sequencer's done, ready and missing-address indications.

Each status bit that changes from 0 to 1 latches a matching bit in a cause register. Software clears a cause bit by writing 1 to it. A mask register selects which causes may drive the single interrupt line. Because only rising edges are recorded, software that waits on a condition should first read the live status word, then unmask the cause.

Top module: `fifo_irq_status`

## Requirements
- R1: While reset is high, and on the first clock after reset, the status word, cause register and mask register are all zero and the interrupt line is low. Status bit positions are fixed: 0 transfer done, 1 transfer ready, 2 read ready, 3 write ready, 4 read empty, 5 read full, 6 write empty, 7 write full, 8 read underflow, 9 read overflow, 10 write underflow, 11 write overflow, 12 address not configured.
- R2: Status bit 2 (read ready) is 1 exactly when the read FIFO level, in bytes, is greater than the 3-bit read threshold.
- R3: Status bit 3 (write ready) is 1 exactly when the write FIFO level, in bytes, is less than or equal to the 3-bit write threshold.
- R4: For each FIFO, the empty bit (4 read, 6 write) is 1 when its level is 0, and the full bit (5 read, 7 write) is 1 when its level equals the FIFO depth of 8 bytes. Empty and full are never set together.
- R5: A one-cycle error pulse sets its status bit (8 to 11), and the bit stays set until a flush or a soft-reset input clears all four. When a pulse and a clear arrive in the same cycle, the clear wins.
- R6: A cause bit is set only in the cycle in which its status bit changes from 0 to 1. A status bit that stays high does not set the cause bit again after it has been cleared.
- R7: A cause-clear write clears every cause bit that has a 1 in the write data, and an all-ones write clears all causes. A rise on the same bit in the same cycle takes priority, so the bit ends up set.
- R8: The interrupt line equals the OR of the cause bits ANDed with the mask register. With a mask of zero the line stays low whatever the causes hold.
- R9: A change on an input shows up in the status word, the cause register and the interrupt line on the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_level | input | 4 | Read FIFO fill level in bytes (0 to 8) |
| wr_level | input | 4 | Write FIFO fill level in bytes (0 to 8) |
| rd_thr | input | 3 | Read ready threshold |
| wr_thr | input | 3 | Write ready threshold |
| rd_udf_pulse | input | 1 | Read FIFO underflow event |
| rd_ovf_pulse | input | 1 | Read FIFO overflow event |
| wr_udf_pulse | input | 1 | Write FIFO underflow event |
| wr_ovf_pulse | input | 1 | Write FIFO overflow event |
| flush | input | 1 | FIFO flush; clears the sticky error bits |
| soft_rst | input | 1 | Soft reset; clears the sticky error bits |
| xfer_done | input | 1 | Sequencer reports that the transfer has finished |
| xfer_rdy | input | 1 | Sequencer reports that it is idle and ready |
| addr_unset | input | 1 | Sequencer reports that no address is configured |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 13 | New mask value |
| cause_clr_we | input | 1 | Write-one-to-clear strobe for the cause register |
| cause_clr_wdata | input | 13 | Bits of the cause register to clear |
| status | output | 13 | Registered live status word |
| cause | output | 13 | Latched rising-edge causes |
| mask | output | 13 | Interrupt mask register |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default depth of 8 bytes and 3-bit thresholds. At that size both FIFOs can be driven to every level from empty to full, and every threshold value from 0 to 7 can be tried, including threshold 7 against level 7 and level 8 at the top of the range. With 13 status bits, an all-ones clear word and an all-ones mask cover the whole register, and the set-over-clear and clear-over-pulse collisions can be forced cycle by cycle.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
  localparam int STAT_W = 13;
  localparam int ERR_W  = 4;

  localparam int B_DONE = 0;
  localparam int B_XRDY = 1;
  localparam int B_RRDY = 2;
  localparam int B_WRDY = 3;
  localparam int B_REMP = 4;
  localparam int B_RFUL = 5;
  localparam int B_WEMP = 6;
  localparam int B_WFUL = 7;
  localparam int B_ERR0 = 8;   // rd underflow, rd overflow, wr underflow, wr overflow
  localparam int B_ADDR = 12;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/irqst_flags.sv
module irqst_flags #(
  parameter int DEPTH = 8,
  parameter int TH_W  = 3,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] rd_level,
  input  logic [LVL_W-1:0] wr_level,
  input  logic [TH_W-1:0]  rd_thr,
  input  logic [TH_W-1:0]  wr_thr,
  output logic             rd_rdy,
  output logic             wr_rdy,
  output logic             rd_empty,
  output logic             rd_full,
  output logic             wr_empty,
  output logic             wr_full
);
  localparam int CMP_W = (LVL_W > TH_W) ? LVL_W : TH_W;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [CMP_W-1:0] rl_x, wl_x, rt_x, wt_x;

  always_comb begin
    rl_x     = CMP_W'(rd_level);
    wl_x     = CMP_W'(wr_level);
    rt_x     = CMP_W'(rd_thr);
    wt_x     = CMP_W'(wr_thr);
    rd_rdy   = rl_x > rt_x;
    wr_rdy   = wl_x <= wt_x;
    rd_empty = rd_level == '0;
    wr_empty = wr_level == '0;
    rd_full  = rd_level == FULL_LVL;
    wr_full  = wr_level == FULL_LVL;
  end
endmodule

// File: rtl/irqst_sticky.sv
module irqst_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_pulse,
  output logic [W-1:0] err_next,
  output logic [W-1:0] err_q
);
  always_comb begin
    if (clr) err_next = '0;
    else     err_next = err_q | set_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_next;
  end

  // R5: without a clear, no recorded error is lost
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R5: a clear empties the record, even against a same-cycle pulse
  p_sticky_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (err_q == '0));
endmodule

// File: rtl/irqst_cause.sv
module irqst_cause #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_next,
  input  logic [W-1:0] stat_q,
  input  logic         clr_we,
  input  logic [W-1:0] clr_wdata,
  output logic [W-1:0] cause_next,
  output logic [W-1:0] cause_q
);
  logic [W-1:0] rise, clr_bits;

  always_comb begin
    rise       = stat_next & ~stat_q;
    clr_bits   = clr_we ? clr_wdata : '0;
    cause_next = (cause_q & ~clr_bits) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_next;
  end

  // R6: a newly set cause bit always coincides with a 0-to-1 status change
  p_cause_needs_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (cause_q & ~$past(cause_q) & ~(stat_q & ~$past(stat_q))) == '0);

  // R7: written ones clear, unless that status bit rose in the same cycle
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((cause_q & $past(clr_wdata) & ~(stat_q & ~$past(stat_q))) == '0));
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import irqst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TH_W  = 3,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  rd_level,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic [TH_W-1:0]   rd_thr,
  input  logic [TH_W-1:0]   wr_thr,
  input  logic              rd_udf_pulse,
  input  logic              rd_ovf_pulse,
  input  logic              wr_udf_pulse,
  input  logic              wr_ovf_pulse,
  input  logic              flush,
  input  logic              soft_rst,
  input  logic              xfer_done,
  input  logic              xfer_rdy,
  input  logic              addr_unset,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic              cause_clr_we,
  input  logic [STAT_W-1:0] cause_clr_wdata,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] cause,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic rd_rdy, wr_rdy, rd_empty, rd_full, wr_empty, wr_full;
  logic [ERR_W-1:0] err_next, err_q;
  stat_t status_next, status_q, cause_next, cause_q, mask_next, mask_q;
  logic  irq_q;

  irqst_flags #(.DEPTH(DEPTH), .TH_W(TH_W), .LVL_W(LVL_W)) u_flags (
    .rd_level (rd_level), .wr_level (wr_level),
    .rd_thr   (rd_thr),   .wr_thr   (wr_thr),
    .rd_rdy   (rd_rdy),   .wr_rdy   (wr_rdy),
    .rd_empty (rd_empty), .rd_full  (rd_full),
    .wr_empty (wr_empty), .wr_full  (wr_full)
  );

  irqst_sticky #(.W(ERR_W)) u_sticky (
    .clk       (clk),
    .rst       (rst),
    .clr       (flush | soft_rst),
    .set_pulse ({wr_ovf_pulse, wr_udf_pulse, rd_ovf_pulse, rd_udf_pulse}),
    .err_next  (err_next),
    .err_q     (err_q)
  );

  always_comb begin
    status_next                        = '0;
    status_next[B_DONE]                = xfer_done;
    status_next[B_XRDY]                = xfer_rdy;
    status_next[B_RRDY]                = rd_rdy;
    status_next[B_WRDY]                = wr_rdy;
    status_next[B_REMP]                = rd_empty;
    status_next[B_RFUL]                = rd_full;
    status_next[B_WEMP]                = wr_empty;
    status_next[B_WFUL]                = wr_full;
    status_next[B_ERR0 +: ERR_W]       = err_next;
    status_next[B_ADDR]                = addr_unset;
  end

  irqst_cause #(.W(STAT_W)) u_cause (
    .clk        (clk),
    .rst        (rst),
    .stat_next  (status_next),
    .stat_q     (status_q),
    .clr_we     (cause_clr_we),
    .clr_wdata  (cause_clr_wdata),
    .cause_next (cause_next),
    .cause_q    (cause_q)
  );

  always_comb mask_next = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_next;
      mask_q   <= mask_next;
      irq_q    <= |(cause_next & mask_next);
    end
  end

  assign status = status_q;
  assign cause  = cause_q;
  assign mask   = mask_q;
  assign irq    = irq_q;

  // R8: the interrupt register tracks the cause and mask registers
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(cause_q & mask_q));

  // R4: empty and full are exclusive for both FIFOs
  p_empty_full_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(status_q[B_REMP] && status_q[B_RFUL]) && !(status_q[B_WEMP] && status_q[B_WFUL]));

  // R9: a sticky bit changes only one edge after a pulse or clear input
  p_err_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (status_q[B_ERR0 +: ERR_W] != $past(status_q[B_ERR0 +: ERR_W])) |->
      ($past(flush | soft_rst) || ($past({wr_ovf_pulse, wr_udf_pulse, rd_ovf_pulse, rd_udf_pulse}) != '0)));
endmodule

// File: tb/fifo_irq_status_tb.sv
module fifo_irq_status_tb;
  localparam int SW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] rd_level = '0, wr_level = '0;
  logic [2:0] rd_thr = '0, wr_thr = '0;
  logic rd_udf_pulse = 0, rd_ovf_pulse = 0, wr_udf_pulse = 0, wr_ovf_pulse = 0;
  logic flush = 0, soft_rst = 0, xfer_done = 0, xfer_rdy = 0, addr_unset = 0;
  logic mask_we = 0, cause_clr_we = 0;
  logic [SW-1:0] mask_wdata = '0, cause_clr_wdata = '0;
  logic [SW-1:0] status, cause, mask;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fifo_irq_status u_dut (
    .clk(clk), .rst(rst), .rd_level(rd_level), .wr_level(wr_level),
    .rd_thr(rd_thr), .wr_thr(wr_thr),
    .rd_udf_pulse(rd_udf_pulse), .rd_ovf_pulse(rd_ovf_pulse),
    .wr_udf_pulse(wr_udf_pulse), .wr_ovf_pulse(wr_ovf_pulse),
    .flush(flush), .soft_rst(soft_rst), .xfer_done(xfer_done),
    .xfer_rdy(xfer_rdy), .addr_unset(addr_unset),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cause_clr_we(cause_clr_we), .cause_clr_wdata(cause_clr_wdata),
    .status(status), .cause(cause), .mask(mask), .irq(irq)
  );

  // {rd_level[3:0], rd_thr[2:0], wr_level[3:0], wr_thr[2:0], expected status[7:2]}
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd0, 3'd0, 4'd0, 3'd0, 6'b010110},
    {4'd1, 3'd0, 4'd1, 3'd0, 6'b000001},
    {4'd8, 3'd7, 4'd8, 3'd7, 6'b101001},
    {4'd7, 3'd7, 4'd7, 3'd7, 6'b000010},
    {4'd4, 3'd3, 4'd3, 3'd3, 6'b000011},
    {4'd3, 3'd3, 4'd4, 3'd3, 6'b000000},
    {4'd8, 3'd0, 4'd0, 3'd7, 6'b011011},
    {4'd0, 3'd5, 4'd8, 3'd0, 6'b100100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock edge, then settle 1 ns past it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 status in reset", 32'(status), 32'h0);
    chk("R1 cause in reset", 32'(cause), 32'h0);
    chk("R1 mask in reset", 32'(mask), 32'h0);
    chk("R1 irq in reset", 32'(irq), 32'h0);

    rst = 1'b0;
    step();
    // levels 0, thresholds 0: write ready (3), read empty (4), write empty (6)
    chk("R1 R4 status after reset", 32'(status), 32'h058);
    chk("R6 causes from rise out of reset", 32'(cause), 32'h058);
    chk("R8 irq with zero mask", 32'(irq), 32'h0);

    cause_clr_we = 1'b1; cause_clr_wdata = '1;
    step();
    cause_clr_we = 1'b0;
    chk("R7 all-ones clears every cause", 32'(cause), 32'h0);
    step();
    chk("R6 held level does not set cause again", 32'(cause), 32'h0);

    // threshold, empty and full vectors
    for (int i = 0; i < NVEC; i++) begin
      {rd_level, rd_thr, wr_level, wr_thr} = VEC[i][19:6];
      step();
      chk($sformatf("R2 R3 R4 vector %0d status[7:2]", i), 32'(status[7:2]), 32'(VEC[i][5:0]));
    end

    rd_level = '0; wr_level = '0; rd_thr = '0; wr_thr = '0;
    step();
    cause_clr_we = 1'b1; cause_clr_wdata = '1;
    step();
    cause_clr_we = 1'b0;
    chk("R7 clear after vectors", 32'(cause), 32'h0);

    mask_we = 1'b1; mask_wdata = '1;
    step();
    mask_we = 1'b0;
    chk("R8 mask loaded", 32'(mask), 32'h1FFF);
    chk("R8 no cause no irq", 32'(irq), 32'h0);

    xfer_done = 1'b1; xfer_rdy = 1'b1;
    #1;
    chk("R9 status not yet updated before edge", 32'(status[1:0]), 32'h0);
    step();
    chk("R9 status bits 0 and 1 after edge", 32'(status[1:0]), 32'h3);
    chk("R6 done and ready rise set causes", 32'(cause), 32'h003);
    chk("R8 irq with mask all ones", 32'(irq), 32'h1);

    cause_clr_we = 1'b1; cause_clr_wdata = 13'h001;
    step();
    cause_clr_we = 1'b0;
    chk("R7 single-bit clear", 32'(cause), 32'h002);
    chk("R8 irq still set", 32'(irq), 32'h1);

    mask_we = 1'b1; mask_wdata = '0;
    step();
    mask_we = 1'b0;
    chk("R8 zero mask forces irq low", 32'(irq), 32'h0);
    chk("R8 cause kept under zero mask", 32'(cause), 32'h002);

    addr_unset = 1'b1; cause_clr_we = 1'b1; cause_clr_wdata = 13'h1000;
    step();
    cause_clr_we = 1'b0;
    chk("R7 rise wins over same-cycle clear", 32'(cause), 32'h1002);

    rd_ovf_pulse = 1'b1;
    step();
    rd_ovf_pulse = 1'b0;
    chk("R5 overflow pulse sets bit 9", 32'(status[9]), 32'h1);
    chk("R6 overflow rise sets cause 9", 32'(cause[9]), 32'h1);
    step();
    chk("R5 bit 9 stays set", 32'(status[9]), 32'h1);

    flush = 1'b1;
    step();
    flush = 1'b0;
    chk("R5 flush clears sticky bits", 32'(status[11:8]), 32'h0);

    wr_udf_pulse = 1'b1; flush = 1'b1;
    step();
    wr_udf_pulse = 1'b0; flush = 1'b0;
    chk("R5 clear wins over pulse", 32'(status[11:8]), 32'h0);

    wr_ovf_pulse = 1'b1;
    step();
    wr_ovf_pulse = 1'b0;
    chk("R5 write overflow sets bit 11", 32'(status[11:8]), 32'h8);
    soft_rst = 1'b1;
    step();
    soft_rst = 1'b0;
    chk("R5 soft reset clears sticky bits", 32'(status[11:8]), 32'h0);

    cause_clr_we = 1'b1; cause_clr_wdata = '1;
    step();
    cause_clr_we = 1'b0;
    rd_ovf_pulse = 1'b1;
    step();
    rd_ovf_pulse = 1'b0;
    chk("R6 new rise after clear sets cause again", 32'(cause), 32'h200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule